// File: doc/BRIEF.md
# Sticky register lock controller

This block keeps a small bank of 16-bit security-sensitive configuration registers next to a lock memory that holds one two-bit lock entry per register. Early boot code writes the configuration values, then writes the lock entries. From then on, a locked register refuses writes, reads, or both, and nothing short of the asynchronous power-on reset can lift those locks.

All access goes through one simple register port: an address, a write strobe, a read strobe, write data and registered read data. A blocked or stray access raises a one-cycle violation pulse. Scan-mode, debug-unlock and JTAG-unlock indications come in as inputs. They have no functional path into the lock or data state, so none of them can open a lock, clear the lock memory or reset a register.

Top module: `sticky_lock_bank`

## Requirements
- R1: While rstN is low, and after it is released, every data register and every lock entry is zero, busRdata is 0x0000 and violation is low.
- R2: Addresses 0 to NUM_REGS-1 select data register i. Addresses NUM_REGS to 2*NUM_REGS-1 select lock entry i (address minus NUM_REGS). In a lock entry, bit 0 is the write lock and bit 1 is the read lock. Read data and the violation pulse appear in the cycle after the request. When busWe and busRe are both high, the write is performed and no read takes place.
- R3: A write to a data register whose write lock is clear stores busWdata. A later read returns that value.
- R4: A write to a data register whose write lock is set leaves the stored value unchanged and raises violation for exactly one cycle.
- R5: A write to a lock entry ORs busWdata[1:0] into the entry. A lock bit that is set is never cleared by any bus write.
- R6: A write to a lock entry whose own write-lock bit is set is ignored and raises violation.
- R7: A read of a data register whose read lock is set returns 0x0000 and raises violation. The read lock does not block writes, and the write lock does not block reads.
- R8: Asserting scanMode or debugUnlock never lets a write through to a write-locked register and never lets a read-locked register be read.
- R9: Asserting jtagUnlock neither clears nor alters any lock entry or data register.
- R10: A read or write at an address of 2*NUM_REGS or above returns 0x0000 on a read, changes no state and raises violation.
- R11: A read of a lock entry is always permitted. It returns the entry in bits 1:0 with all upper bits zero, and it raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| violation | output | 1 | One-cycle pulse on a blocked or out-of-range access |
| scanMode | input | 1 | Scan mode indication (no effect on locks) |
| debugUnlock | input | 1 | Debug-unlock indication (no effect on locks) |
| jtagUnlock | input | 1 | JTAG-unlock indication (no effect on locks) |

## Verification
The bench uses the default parameters: NUM_REGS of 6, DATA_W of 16 and ADDR_W of 4. With these values all six data registers and all six lock entries can be addressed, together with four out-of-range addresses (12 to 15), so every entry can be taken through the unlocked, write-locked, read-locked and fully locked states. It also raises the three debug inputs while locked registers are accessed. Finally, it applies a second power-on reset to show that only that reset lifts the locks.

// File: rtl/sticky_lock_pkg.sv
package sticky_lock_pkg;
  // Layout of one lock entry; the control and the datapath both decode it.
  localparam int LOCK_W    = 2;
  localparam int WLOCK_BIT = 0;
  localparam int RLOCK_BIT = 1;
  // Width of the register index that is carried in the strobe struct.
  localparam int IDX_W     = 8;

  typedef struct packed {
    logic             dataWr;  // store write data into data register idx
    logic             lockWr;  // OR write data into lock entry idx
    logic             dataRd;  // load data register idx into read data
    logic             lockRd;  // load lock entry idx into read data
    logic             zeroRd;  // load zero into read data
    logic             flag;    // raise the violation pulse
    logic [IDX_W-1:0] idx;     // register / entry index
  } strobe_t;
endpackage

// File: rtl/sticky_lock_ctrl.sv
module sticky_lock_ctrl
  import sticky_lock_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 4
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [NUM_REGS-1:0] wLockVec,
  input  logic [NUM_REGS-1:0] rLockVec,
  output strobe_t             strobes
);
  localparam int          LOCK_BASE = NUM_REGS;
  localparam int          BANK_END  = 2 * NUM_REGS;
  localparam logic [ADDR_W:0]   LOCK_BASE_X = (ADDR_W+1)'(LOCK_BASE);
  localparam logic [ADDR_W:0]   BANK_END_X  = (ADDR_W+1)'(BANK_END);
  localparam logic [ADDR_W-1:0] LOCK_BASE_A = ADDR_W'(LOCK_BASE);

  logic [ADDR_W:0]  addrExt;
  logic             inData;
  logic             inLock;
  logic [IDX_W-1:0] idx;
  logic             curWl;
  logic             curRl;

  always_comb begin
    addrExt = {1'b0, busAddr};
    inData  = addrExt < LOCK_BASE_X;
    inLock  = !inData && (addrExt < BANK_END_X);
    idx     = inData ? IDX_W'(busAddr) : IDX_W'(busAddr - LOCK_BASE_A);
  end

  // Lock bits of the addressed index; both the data register and its
  // lock entry are governed by the same entry.
  always_comb begin
    curWl = 1'b0;
    curRl = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if ((inData || inLock) && idx == IDX_W'(i)) begin
        curWl = wLockVec[i];
        curRl = rLockVec[i];
      end
    end
  end

  always_comb begin
    strobes     = '0;
    strobes.idx = idx;
    if (busWe) begin
      if (inData) begin
        strobes.dataWr = !curWl;
        strobes.flag   = curWl;
      end else if (inLock) begin
        strobes.lockWr = !curWl;
        strobes.flag   = curWl;
      end else begin
        strobes.flag   = 1'b1;
      end
    end else if (busRe) begin
      if (inData) begin
        strobes.dataRd = !curRl;
        strobes.zeroRd = curRl;
        strobes.flag   = curRl;
      end else if (inLock) begin
        strobes.lockRd = 1'b1;
      end else begin
        strobes.zeroRd = 1'b1;
        strobes.flag   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sticky_lock_dp.sv
module sticky_lock_dp
  import sticky_lock_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                violation,
  output logic [NUM_REGS-1:0] wLockVec,
  output logic [NUM_REGS-1:0] rLockVec
);
  logic [DATA_W-1:0] dataArr [NUM_REGS];
  logic [LOCK_W-1:0] lockArr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    logic              hit;
    logic [DATA_W-1:0] dataQ;
    logic [LOCK_W-1:0] lockQ;

    assign hit = strobes.idx == IDX_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       dataQ <= '0;
      else if (strobes.dataWr && hit)  dataQ <= busWdata;
    end

    // Lock entry: power-on reset is its only clear; writes can only add bits.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       lockQ <= '0;
      else if (strobes.lockWr && hit)  lockQ <= lockQ | busWdata[LOCK_W-1:0];
    end

    assign dataArr[g]  = dataQ;
    assign lockArr[g]  = lockQ;
    assign wLockVec[g] = lockQ[WLOCK_BIT];
    assign rLockVec[g] = lockQ[RLOCK_BIT];
  end

  logic [DATA_W-1:0] dSel;
  logic [LOCK_W-1:0] lSel;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    dSel = '0;
    lSel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobes.idx == IDX_W'(i)) begin
        dSel = dataArr[i];
        lSel = lockArr[i];
      end
    end
    rdNext = busRdata;
    if (strobes.dataRd)      rdNext = dSel;
    else if (strobes.lockRd) rdNext = DATA_W'(lSel);
    else if (strobes.zeroRd) rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      violation <= 1'b0;
    end else begin
      busRdata  <= rdNext;
      violation <= strobes.flag;
    end
  end
endmodule

// File: rtl/sticky_lock_bank.sv
module sticky_lock_bank
  import sticky_lock_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              violation,
  input  logic              scanMode,
  input  logic              debugUnlock,
  input  logic              jtagUnlock
);
  strobe_t             strobes;
  logic [NUM_REGS-1:0] wLockVec;
  logic [NUM_REGS-1:0] rLockVec;

  // The test and debug indications are deliberately given no path into the
  // lock decision or into any reset; they end here.
  logic unusedModes;
  assign unusedModes = scanMode | debugUnlock | jtagUnlock;

  sticky_lock_ctrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .wLockVec(wLockVec),
    .rLockVec(rLockVec),
    .strobes (strobes)
  );

  sticky_lock_dp #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .violation(violation),
    .wLockVec (wLockVec),
    .rLockVec (rLockVec)
  );
endmodule

// File: rtl/sticky_lock_bank_chk.sv
module sticky_lock_bank_chk #(
  parameter int NUM_REGS = 6,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic                busRe,
  input logic [DATA_W-1:0]   busRdata,
  input logic                violation,
  input logic                scanMode,
  input logic                debugUnlock,
  input logic                jtagUnlock,
  input logic [NUM_REGS-1:0] wLockVec,
  input logic [NUM_REGS-1:0] rLockVec
);
  logic inData, inLock, outRange, wl, rl;

  always_comb begin
    inData   = 32'(busAddr) < NUM_REGS;
    inLock   = !inData && 32'(busAddr) < 2 * NUM_REGS;
    outRange = !inData && !inLock;
    wl = 1'b0;
    rl = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if ((inData && 32'(busAddr) == i) || (inLock && 32'(busAddr) == i + NUM_REGS)) begin
        wl = wLockVec[i];
        rl = rLockVec[i];
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe || busRe) |=> !violation);

  a_r4_locked_write_flags: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && inData && wl) |=> violation);

  a_r5_locks_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((wLockVec & $past(wLockVec)) == $past(wLockVec)) &&
    ((rLockVec & $past(rLockVec)) == $past(rLockVec)));

  a_r6_locked_entry_flags: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && inLock && wl) |=> violation);

  a_r7_read_locked_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && inData && rl) |=> (violation && busRdata == '0));

  a_r8_debug_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && inData && wl && (scanMode || debugUnlock)) |=> violation);

  a_r9_jtag_keeps_locks: assert property (@(posedge clk) disable iff (!rstN)
    jtagUnlock |=> ((wLockVec & $past(wLockVec)) == $past(wLockVec)) &&
                   ((rLockVec & $past(rLockVec)) == $past(rLockVec)));

  a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    ((busWe || busRe) && outRange) |=> violation);

  a_r11_lock_read_clean: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && inLock) |=> (!violation && busRdata[DATA_W-1:2] == '0));
endmodule

bind sticky_lock_bank sticky_lock_bank_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) uChk (.*);

// File: tb/sim_sticky_lock_bank.sv
`timescale 1ns/1ps
module sim_sticky_lock_bank;
  localparam int NR = 6;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] busAddr;
  logic          busWe, busRe;
  logic [DW-1:0] busWdata;
  logic [DW-1:0] busRdata;
  logic          violation;
  logic          scanMode, debugUnlock, jtagUnlock;

  always #2 clk = ~clk;

  sticky_lock_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .violation(violation),
    .scanMode(scanMode), .debugUnlock(debugUnlock), .jtagUnlock(jtagUnlock)
  );

  typedef struct {
    logic [DW-1:0] rd;
    logic          chkRd;
    logic          viol;
    int            due;
    string         tag;
  } item_t;

  item_t         q[$];
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  bit            done = 0;
  logic [DW-1:0] mData [NR];
  logic [1:0]    mLock [NR];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic modelClear();
    for (int i = 0; i < NR; i++) begin
      mData[i] = '0;
      mLock[i] = '0;
    end
  endtask

  task automatic expectVal(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, expectation from the requirement model.
  task automatic access(input logic we, input logic re, input int addr,
                        input logic [DW-1:0] wd, input string tag);
    item_t it;
    it.rd = '0; it.chkRd = 1'b0; it.viol = 1'b0; it.tag = tag;
    if (we) begin
      if (addr < NR) begin
        if (mLock[addr][0]) it.viol = 1'b1; else mData[addr] = wd;
      end else if (addr < 2*NR) begin
        if (mLock[addr-NR][0]) it.viol = 1'b1; else mLock[addr-NR] = mLock[addr-NR] | wd[1:0];
      end else it.viol = 1'b1;
    end else if (re) begin
      it.chkRd = 1'b1;
      if (addr < NR) begin
        if (mLock[addr][1]) it.viol = 1'b1; else it.rd = mData[addr];
      end else if (addr < 2*NR) it.rd = DW'(mLock[addr-NR]);
      else it.viol = 1'b1;
    end
    @(negedge clk);
    busWe = we; busRe = re; busAddr = AW'(addr); busWdata = wd;
    it.due = cyc + 1;
    q.push_back(it);
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] wd, input string tag);
    access(1'b1, 1'b0, addr, wd, tag);
  endtask

  task automatic rd(input int addr, input string tag);
    access(1'b0, 1'b1, addr, '0, tag);
  endtask

  task automatic drain();
    access(1'b0, 1'b0, 0, '0, "idle");
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops each expected item in the cycle its result is due.
  always @(negedge clk) begin
    if (q.size() != 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      expectVal({it.tag, " violation"}, DW'(violation), DW'(it.viol));
      if (it.chkRd) expectVal({it.tag, " rdata"}, busRdata, it.rd);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWe = 0; busRe = 0; busAddr = '0; busWdata = '0;
    scanMode = 0; debugUnlock = 0; jtagUnlock = 0;
    modelClear();
    repeat (3) @(negedge clk);
    expectVal("R1 rdata in reset", busRdata, '0);
    expectVal("R1 violation in reset", DW'(violation), '0);
    rstN = 1'b1;
    for (int a = 0; a < 2*NR; a++) rd(a, "R1 reset read");

    // R3: unlocked writes land and read back
    for (int a = 0; a < NR; a++) wr(a, DW'(16'h1100 + a * 16'h0111), "R3 write");
    for (int a = 0; a < NR; a++) rd(a, "R3 readback");

    // R2: simultaneous write and read performs only the write
    access(1'b1, 1'b1, 0, 16'hBEEF, "R2 write priority");
    rd(0, "R2 after write priority");

    // R5: OR update, zeros never clear a set bit
    wr(NR+2, 16'h0002, "R5 set read lock");
    wr(NR+2, 16'h0000, "R5 zero write");
    rd(NR+2, "R5 entry sticky");
    wr(NR+1, 16'hFFFD, "R5 set write lock only bit0");
    rd(NR+1, "R5 entry value");

    // R4: write-locked register
    wr(1, 16'hDEAD, "R4 locked write");
    rd(1, "R4 value kept");
    access(1'b0, 1'b0, 0, '0, "R4 pulse one cycle");

    // R6: locked entry cannot be changed
    wr(NR+1, 16'h0000, "R6 clear attempt");
    wr(NR+1, 16'h0002, "R6 add attempt");
    rd(NR+1, "R6 entry kept");

    // R7: read lock blocks reads but not writes; write lock does not block reads
    rd(2, "R7 read locked");
    wr(2, 16'h5A5A, "R7 write under read lock");
    rd(2, "R7 still zero");
    rd(1, "R7 write lock allows read");
    wr(NR+3, 16'h0003, "R7 lock both");
    wr(3, 16'h7777, "R7 both locked write");
    rd(3, "R7 both locked read");

    // R8: scan and debug unlock do not bypass
    scanMode = 1'b1;
    wr(1, 16'h1234, "R8 scan write");
    rd(2, "R8 scan read");
    scanMode = 1'b0; debugUnlock = 1'b1;
    wr(3, 16'h4321, "R8 debug write");
    rd(3, "R8 debug read");
    scanMode = 1'b1;
    wr(NR+1, 16'h0000, "R8 both lock clear");
    drain();
    scanMode = 1'b0; debugUnlock = 1'b0;
    rd(1, "R8 value after modes");

    // R9: JTAG unlock alters nothing
    jtagUnlock = 1'b1;
    repeat (4) access(1'b0, 1'b0, 0, '0, "R9 idle under unlock");
    for (int a = 0; a < 2*NR; a++) rd(a, "R9 state under unlock");
    wr(1, 16'h0BAD, "R9 write under unlock");
    drain();
    jtagUnlock = 1'b0;
    for (int a = 0; a < NR; a++) rd(NR + a, "R9 entries after unlock");

    // R10: out of range
    for (int a = 2*NR; a < 16; a++) begin
      wr(a, 16'hFFFF, "R10 write");
      rd(a, "R10 read");
    end
    for (int a = 0; a < 2*NR; a++) rd(a, "R10 no side effect");

    // R11: lock entries always readable, upper bits zero
    wr(NR+5, 16'hFFFF, "R11 lock all bits of last");
    for (int a = 0; a < NR; a++) rd(NR + a, "R11 entry read");

    // R1: only power-on reset clears the locks
    drain();
    @(negedge clk);
    rstN = 1'b0;
    modelClear();
    @(negedge clk);
    expectVal("R1 rdata in second reset", busRdata, '0);
    expectVal("R1 violation in second reset", DW'(violation), '0);
    rstN = 1'b1;
    for (int a = 0; a < 2*NR; a++) rd(a, "R1 after second reset");
    wr(1, 16'hCAFE, "R1 write after reset");
    rd(1, "R1 readback after reset");

    drain();
    done = 1;
    summary();
    $finish;
  end
endmodule